// File: doc/BRIEF.md
# Board-ID Packet Router

This block sits at a routing stage of a multi-board compute fabric. Each packet carries a one-bit leg flag plus a source address and a destination address. Each address is a board field in its upper bits and an offset below it. The leg flag picks which address is compared against this board's fixed identifier. When the flag is 0, the packet is on its way to read its source operand, so the source board is compared. When the flag is 1, the packet has been multiplied and is heading for its destination, so the destination board is compared. Packets whose board matches are kept on this board in one of two local queues, chosen by the leg flag. All other packets go to a remote queue, and from there they are sent out over the inter-board bus.

The same router also watches the inter-board bus. Every bus transfer is seen by all boards and is tagged with a target board number. The router takes in only the transfers tagged with its own number and places each one in the local queue named by the packet's leg flag. Every packet goes through the router, whether or not it has to leave the board. Gather and scatter traffic therefore share one path.

Top module: `bir_router`

## Requirements
- R1: After reset all three queues are empty: `srcq_valid`, `dstq_valid` and `rmtq_valid` are 0.
- R2: A local packet with flag bit (bit PKT_W-1) 0 whose source board field equals BOARD_ID enters the source-read queue and appears unchanged at `srcq_pkt`.
- R3: A local packet with flag bit 1 whose destination board field equals BOARD_ID enters the destination-read queue and appears unchanged at `dstq_pkt`.
- R4: A local packet whose compared board field differs from BOARD_ID enters the remote queue unchanged. While that packet is at the head, `rmtq_board` shows the compared board field.
- R5: A bus packet whose `bus_board` differs from BOARD_ID changes no queue.
- R6: If the target queue of the local packet is full, `in_ready` is 0 and the packet is neither written nor lost. It is accepted once space frees.
- R7: If an accepted bus packet and a local packet target the same local queue in one cycle, the bus packet is written and `in_ready` is 0.
- R8: Each queue delivers packets in the order it accepted them.
- R9: `bus_ready` is 0 only when `bus_valid` is 1, `bus_board` equals BOARD_ID and the queue chosen by the bus packet's flag bit is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Local packet offered |
| in_pkt | input | PKT_W | Local packet {flag, src{board,offset}, dst{board,offset}, data} |
| in_ready | output | 1 | Local packet accepted this cycle when valid |
| bus_valid | input | 1 | Bus transfer present |
| bus_board | input | BOARD_W | Target board of the bus transfer |
| bus_pkt | input | PKT_W | Bus packet, same layout as `in_pkt` |
| bus_ready | output | 1 | Bus transfer can be taken (or is not ours) |
| srcq_valid | output | 1 | Source-read queue non-empty |
| srcq_pkt | output | PKT_W | Head of source-read queue |
| srcq_ready | input | 1 | Pop source-read queue |
| dstq_valid | output | 1 | Destination-read queue non-empty |
| dstq_pkt | output | PKT_W | Head of destination-read queue |
| dstq_ready | input | 1 | Pop destination-read queue |
| rmtq_valid | output | 1 | Remote queue non-empty |
| rmtq_pkt | output | PKT_W | Head of remote queue |
| rmtq_board | output | BOARD_W | Board the remote head must travel to |
| rmtq_ready | input | 1 | Pop remote queue |

## Verification
The embedded properties assume that `in_pkt`, `bus_pkt` and `bus_board` hold known values in any cycle where their valid is high, and that a bus transfer presents its board tag in the same cycle as its payload. The bench drives complete, defined values on every input in every cycle. It changes them only at the falling clock edge. About half of the generated board fields are forced to BOARD_ID, so local hits, remote misses, bus hits and ignored bus packets all occur often. Phases with slow consumers fill the queues, which exercises the full-queue stall and the bus-over-local priority.

// File: rtl/bir_pkg.sv
package bir_pkg;
  typedef enum logic [1:0] {
    Q_SRC = 2'd0,
    Q_DST = 2'd1,
    Q_RMT = 2'd2
  } qsel_e;

  localparam int NUM_Q = 3;

  // A hit stays local in the queue named by the leg flag; a miss leaves the board.
  function automatic qsel_e pick_queue(input logic leg, input logic hit);
    if (!hit) return Q_RMT;
    return leg ? Q_DST : Q_SRC;
  endfunction
endpackage

// File: rtl/bir_fifo.sv
module bir_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  output logic             out_valid,
  output logic [WIDTH-1:0] rdata,
  input  logic             out_ready
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign rdata     = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_order_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/bir_classify.sv
module bir_classify
  import bir_pkg::*;
#(
  parameter int          BOARD_W  = 2,
  parameter int          ADDR_W   = 8,
  parameter int          PKT_W    = 33,
  parameter int unsigned BOARD_ID = 1
) (
  input  logic [PKT_W-1:0]   pkt,
  output qsel_e              sel,
  output logic [BOARD_W-1:0] tgt_board,
  output logic               hit
);
  localparam logic [BOARD_W-1:0] MY_ID = BOARD_ID[BOARD_W-1:0];
  localparam int SRC_TOP = PKT_W - 2;
  localparam int DST_TOP = PKT_W - 2 - ADDR_W;

  logic               leg;
  logic [BOARD_W-1:0] src_board, dst_board;

  assign leg       = pkt[PKT_W-1];
  assign src_board = pkt[SRC_TOP -: BOARD_W];
  assign dst_board = pkt[DST_TOP -: BOARD_W];
  assign tgt_board = leg ? dst_board : src_board;
  assign hit       = (tgt_board == MY_ID);
  assign sel       = pick_queue(leg, hit);
endmodule

// File: rtl/bir_router.sv
module bir_router
  import bir_pkg::*;
#(
  parameter int          BOARD_W  = 2,
  parameter int          OFFS_W   = 6,
  parameter int          DATA_W   = 16,
  parameter int          DEPTH    = 4,
  parameter int unsigned BOARD_ID = 1,
  localparam int         ADDR_W   = BOARD_W + OFFS_W,
  localparam int         PKT_W    = 1 + 2 * ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PKT_W-1:0]   in_pkt,
  output logic               in_ready,
  input  logic               bus_valid,
  input  logic [BOARD_W-1:0] bus_board,
  input  logic [PKT_W-1:0]   bus_pkt,
  output logic               bus_ready,
  output logic               srcq_valid,
  output logic [PKT_W-1:0]   srcq_pkt,
  input  logic               srcq_ready,
  output logic               dstq_valid,
  output logic [PKT_W-1:0]   dstq_pkt,
  input  logic               dstq_ready,
  output logic               rmtq_valid,
  output logic [PKT_W-1:0]   rmtq_pkt,
  output logic [BOARD_W-1:0] rmtq_board,
  input  logic               rmtq_ready
);
  localparam logic [BOARD_W-1:0] MY_ID = BOARD_ID[BOARD_W-1:0];

  function automatic logic [BOARD_W-1:0] leg_board(input logic [PKT_W-1:0] p);
    return p[PKT_W-1] ? p[PKT_W-2-ADDR_W -: BOARD_W] : p[PKT_W-2 -: BOARD_W];
  endfunction

  // Named events for the checks
  qsel_e              loc_sel;
  logic [BOARD_W-1:0] loc_tgt;
  logic               loc_hit;
  qsel_e              bus_sel;
  logic               bus_hit;
  logic               bus_push;
  logic               loc_push;
  logic               bus_clash;

  logic [NUM_Q-1:0]   q_full, q_valid, q_ready, q_push;
  logic [PKT_W-1:0]   q_head  [NUM_Q];
  logic [PKT_W-1:0]   q_wdata [NUM_Q];

  bir_classify #(
    .BOARD_W(BOARD_W), .ADDR_W(ADDR_W), .PKT_W(PKT_W), .BOARD_ID(BOARD_ID)
  ) u_cls (
    .pkt(in_pkt), .sel(loc_sel), .tgt_board(loc_tgt), .hit(loc_hit)
  );

  assign bus_hit   = bus_valid && (bus_board == MY_ID);
  assign bus_sel   = pick_queue(bus_pkt[PKT_W-1], 1'b1);
  assign bus_push  = bus_hit && !q_full[bus_sel];
  assign bus_ready = !bus_hit || !q_full[bus_sel];
  assign bus_clash = bus_push && (bus_sel == loc_sel);
  assign in_ready  = !q_full[loc_sel] && !bus_clash;
  assign loc_push  = in_valid && in_ready;

  assign q_ready = {rmtq_ready, dstq_ready, srcq_ready};

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic take_bus, take_loc;
    assign take_bus   = bus_push && (bus_sel == qsel_e'(q));
    assign take_loc   = loc_push && (loc_sel == qsel_e'(q));
    assign q_push[q]  = take_bus || take_loc;
    assign q_wdata[q] = take_bus ? bus_pkt : in_pkt;

    bir_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push[q]), .wdata(q_wdata[q]),
      .full(q_full[q]), .out_valid(q_valid[q]), .rdata(q_head[q]),
      .out_ready(q_ready[q])
    );
  end

  assign srcq_valid = q_valid[Q_SRC];
  assign srcq_pkt   = q_head[Q_SRC];
  assign dstq_valid = q_valid[Q_DST];
  assign dstq_pkt   = q_head[Q_DST];
  assign rmtq_valid = q_valid[Q_RMT];
  assign rmtq_pkt   = q_head[Q_RMT];
  assign rmtq_board = leg_board(q_head[Q_RMT]);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (!srcq_valid && !dstq_valid && !rmtq_valid));
  assert_src_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_push && loc_sel == Q_SRC) |-> (!in_pkt[PKT_W-1] && in_pkt[PKT_W-2 -: BOARD_W] == MY_ID));
  assert_dst_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_push && loc_sel == Q_DST) |-> (in_pkt[PKT_W-1] && in_pkt[PKT_W-2-ADDR_W -: BOARD_W] == MY_ID));
  assert_remote_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_push && loc_sel == Q_RMT) |-> (leg_board(in_pkt) != MY_ID));
  assert_bus_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_board != MY_ID) |-> !bus_push);
  assert_stall_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && q_full[loc_sel]) |-> !in_ready);
  assert_bus_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_push && in_valid && bus_sel == loc_sel) |-> (!in_ready && q_push[bus_sel]));
  assert_bus_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (bus_valid && bus_board == MY_ID));
  assert_push_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_push) <= 2);
endmodule

// File: tb/bir_router_tb.sv
module bir_router_tb;
  localparam int BOARD_W = 2, OFFS_W = 6, DATA_W = 16, DEPTH = 4;
  localparam int unsigned BOARD_ID = 1;
  localparam int ADDR_W = BOARD_W + OFFS_W;
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic in_valid = 0, bus_valid = 0;
  logic [PKT_W-1:0] in_pkt = '0, bus_pkt = '0;
  logic [BOARD_W-1:0] bus_board = '0;
  logic srcq_ready = 0, dstq_ready = 0, rmtq_ready = 0;
  logic in_ready, bus_ready, srcq_valid, dstq_valid, rmtq_valid;
  logic [PKT_W-1:0] srcq_pkt, dstq_pkt, rmtq_pkt;
  logic [BOARD_W-1:0] rmtq_board;

  bir_router #(.BOARD_W(BOARD_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
               .DEPTH(DEPTH), .BOARD_ID(BOARD_ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .in_ready(in_ready), .bus_valid(bus_valid), .bus_board(bus_board),
    .bus_pkt(bus_pkt), .bus_ready(bus_ready),
    .srcq_valid(srcq_valid), .srcq_pkt(srcq_pkt), .srcq_ready(srcq_ready),
    .dstq_valid(dstq_valid), .dstq_pkt(dstq_pkt), .dstq_ready(dstq_ready),
    .rmtq_valid(rmtq_valid), .rmtq_pkt(rmtq_pkt), .rmtq_board(rmtq_board),
    .rmtq_ready(rmtq_ready)
  );

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [PKT_W-1:0] mq0 [$], mq1 [$], mq2 [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic int qsize(input int q);
    return (q == 0) ? mq0.size() : (q == 1) ? mq1.size() : mq2.size();
  endfunction

  // Board the packet is compared against: source board on leg 0, destination on leg 1.
  function automatic int leg_brd(input logic [PKT_W-1:0] p);
    return p[PKT_W-1] ? int'(p[PKT_W-2-ADDR_W -: BOARD_W]) : int'(p[PKT_W-2 -: BOARD_W]);
  endfunction

  function automatic logic [PKT_W-1:0] mk_pkt(input bit leg, input int sb, input int db);
    logic [PKT_W-1:0] p;
    p = {leg, BOARD_W'(sb), OFFS_W'($urandom), BOARD_W'(db), OFFS_W'($urandom), DATA_W'($urandom)};
    return p;
  endfunction

  function automatic int rnd_brd();
    return ($urandom % 2) ? int'(BOARD_ID) : int'($urandom % 4);
  endfunction

  // Compare everything against the model, then advance the model across the coming edge.
  task automatic compare_and_advance();
    int lq, bq;
    bit bhit, bpush, exp_in, exp_bus;
    lq = (leg_brd(in_pkt) == int'(BOARD_ID)) ? (in_pkt[PKT_W-1] ? 1 : 0) : 2;
    bq = bus_pkt[PKT_W-1] ? 1 : 0;
    bhit = bus_valid && (int'(bus_board) == int'(BOARD_ID));
    bpush = bhit && (qsize(bq) < DEPTH);
    exp_bus = !bhit || (qsize(bq) < DEPTH);
    exp_in = (qsize(lq) < DEPTH) && !(bpush && bq == lq);

    chk(bus_ready == exp_bus, "R9", 64'(bus_ready), 64'(exp_bus));
    if (bpush && bq == lq && in_valid)
      chk(in_ready == exp_in, "R7", 64'(in_ready), 64'(exp_in));
    else
      chk(in_ready == exp_in, "R6", 64'(in_ready), 64'(exp_in));

    chk(srcq_valid == (mq0.size() > 0), "R2", 64'(srcq_valid), 64'(mq0.size() > 0));
    if (mq0.size() > 0) chk(srcq_pkt == mq0[0], "R8", 64'(srcq_pkt), 64'(mq0[0]));
    chk(dstq_valid == (mq1.size() > 0), "R3", 64'(dstq_valid), 64'(mq1.size() > 0));
    if (mq1.size() > 0) chk(dstq_pkt == mq1[0], "R8", 64'(dstq_pkt), 64'(mq1[0]));
    chk(rmtq_valid == (mq2.size() > 0), "R4", 64'(rmtq_valid), 64'(mq2.size() > 0));
    if (mq2.size() > 0) begin
      chk(rmtq_pkt == mq2[0], "R4", 64'(rmtq_pkt), 64'(mq2[0]));
      chk(int'(rmtq_board) == leg_brd(mq2[0]), "R4", 64'(rmtq_board), 64'(leg_brd(mq2[0])));
    end

    if (srcq_ready && mq0.size() > 0) void'(mq0.pop_front());
    if (dstq_ready && mq1.size() > 0) void'(mq1.pop_front());
    if (rmtq_ready && mq2.size() > 0) void'(mq2.pop_front());
    if (bpush) begin
      if (bq == 0) mq0.push_back(bus_pkt); else mq1.push_back(bus_pkt);
    end
    if (in_valid && exp_in) begin
      if (lq == 0) mq0.push_back(in_pkt);
      else if (lq == 1) mq1.push_back(in_pkt);
      else mq2.push_back(in_pkt);
    end
  endtask

  task automatic rand_cycle(input int rdy_pct);
    @(negedge clk);
    in_valid   = ($urandom % 100) < 70;
    in_pkt     = mk_pkt($urandom % 2, rnd_brd(), rnd_brd());
    bus_valid  = ($urandom % 100) < 40;
    bus_board  = BOARD_W'(rnd_brd());
    bus_pkt    = mk_pkt($urandom % 2, $urandom % 4, $urandom % 4);
    srcq_ready = ($urandom % 100) < rdy_pct;
    dstq_ready = ($urandom % 100) < rdy_pct;
    rmtq_ready = ($urandom % 100) < rdy_pct;
    #1 compare_and_advance();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1: queues empty out of reset
    chk(!srcq_valid && !dstq_valid && !rmtq_valid, "R1",
        64'({srcq_valid, dstq_valid, rmtq_valid}), 64'd0);

    // R5: bus packet tagged for another board is ignored
    @(negedge clk);
    bus_valid = 1; bus_board = BOARD_W'(BOARD_ID + 1); bus_pkt = mk_pkt(0, BOARD_ID, BOARD_ID);
    #1 compare_and_advance();
    @(negedge clk);
    bus_valid = 0;
    #1;
    chk(!srcq_valid && !dstq_valid, "R5", 64'({srcq_valid, dstq_valid}), 64'd0);
    compare_and_advance();

    // R7: bus and local packet both aim at the source-read queue
    @(negedge clk);
    bus_valid = 1; bus_board = BOARD_W'(BOARD_ID); bus_pkt = mk_pkt(0, 3, 0);
    in_valid = 1; in_pkt = mk_pkt(0, BOARD_ID, 2);
    #1;
    chk(!in_ready, "R7", 64'(in_ready), 64'd0);
    compare_and_advance();
    @(negedge clk);
    bus_valid = 0;
    #1 compare_and_advance();
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(srcq_valid && srcq_pkt[PKT_W-2 -: BOARD_W] == 2'd3, "R7", 64'(srcq_pkt), 64'(mq0[0]));
    compare_and_advance();

    // R6: fill the remote queue with no consumer, then the next miss stalls
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk);
      in_valid = 1; in_pkt = mk_pkt(1, BOARD_ID, 3);
      #1 compare_and_advance();
    end
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(!in_ready || qsize(2) < DEPTH, "R6", 64'(qsize(2)), 64'(DEPTH));
    compare_and_advance();

    for (int i = 0; i < 4000; i++) rand_cycle(90);
    for (int i = 0; i < 4000; i++) rand_cycle(15);
    for (int i = 0; i < 4000; i++) rand_cycle(50);
    finish_run();
  end
endmodule